// File: doc/BRIEF.md
# Shared Memory Host-Controller Arbiter

This block lets an external host and an embedded processor share one local memory bus. The bus reaches two regions: flash and SRAM. The most significant address bit picks the region, and each region has its own programmable wait-state count. Only one access is on the bus at a time. Each access lasts the programmed number of wait states plus one cycle.

The host uses a level strobe with a WAIT handshake. It holds `h_rd` or `h_wr` together with the address, and a transfer completes on the first clock edge at which `h_wait` is low.

- **Host writes.** Every host write is copied into a one-entry posted buffer, so the host is released at once. The write is performed on the bus later.
- **Host reads.** A host read keeps WAIT asserted until its data has been fetched from memory and is being presented.
- **Processor.** The processor holds `p_req` until it receives a single-cycle `p_ack`.
- **Arbitration.** Grants alternate between the two sides. After a host-side access, a requesting processor goes first. After a processor access, pending host work goes first, and a posted write always drains before a host read.

Top module: `shmem_arb`

## Requirements
- R1: An access to a region occupies the bus for that region's wait-state count (0 to 3) plus one cycle. An idle host read therefore sees `h_wait` high for exactly wait-states + 2 sampled cycles.
- R2: A host write that finds the posted buffer empty is accepted with `h_wait` low. It is later written to memory with its address, data and byte enables; `h_be` bit k enables data byte k.
- R3: A host write that finds the buffer full is held with `h_wait` high until the posted entry has drained. It is then accepted and written. With an idle bus this is SRAM wait-states + 2 cycles.
- R4: A host read that arrives while a write is posted is not started until the posted write has been performed, so it returns the written data.
- R5: After a processor access, pending host work is granted first. After a host-side access, a requesting processor is granted first. The sequence processor, posted write, processor, host read follows from this.
- R6: `h_wait` rises in the same cycle a host read strobe is raised. It falls only when the fetched data is already on `h_rdata`.
- R7: Address bit AW-1 = 1 selects `m_cs_flash`, and 0 selects `m_cs_sram`. The two chip selects are never high together.
- R8: Reset empties the posted buffer, so a write accepted just before reset never reaches memory. It also returns the arbiter to idle with no chip select, `p_ack` low and `h_wait` low while no strobe is held.
- R9: A processor access is acknowledged by `p_ack` high for exactly one cycle, on the last cycle of its bus access. Read data is valid on `p_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ws_flash | input | WSW | Wait states for the flash region |
| cfg_ws_sram | input | WSW | Wait states for the SRAM region |
| h_rd | input | 1 | Host read strobe, held until `h_wait` is low |
| h_wr | input | 1 | Host write strobe, held until `h_wait` is low |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_be | input | DW/8 | Host byte enables |
| h_wait | output | 1 | Host hold-off |
| h_rdata | output | DW | Host read data |
| p_req | input | 1 | Processor request, held until `p_ack` |
| p_we | input | 1 | Processor write select |
| p_addr | input | AW | Processor address |
| p_wdata | input | DW | Processor write data |
| p_be | input | DW/8 | Processor byte enables |
| p_ack | output | 1 | Processor access complete (one cycle) |
| p_rdata | output | DW | Processor read data |
| m_cs_flash | output | 1 | Flash chip select |
| m_cs_sram | output | 1 | SRAM chip select |
| m_we | output | 1 | Memory write enable |
| m_addr | output | AW | Memory address |
| m_wdata | output | DW | Memory write data |
| m_be | output | DW/8 | Memory byte enables |
| m_rdata | input | DW | Memory read data |

## Verification
The embedded properties check several rules on every cycle:
- the wait counter stays within the programmed count;
- a posted entry is neither lost nor overwritten before it drains;
- an idle arbiter never starts a host read while a write is posted;
- a processor is granted right after host traffic;
- acknowledges last one cycle;
- a read's WAIT falls only after a host-read bus access.

Some behaviour can only be shown by the bench's scenarios: the exact WAIT lengths per region and setting, byte-lane merging in memory, the interleaved four-access order with its returned data, and the discarding of a posted write by reset.

// File: rtl/shmem_arb.sv
module shmem_arb #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WSW-1:0] cfg_ws_flash,
  input  logic [WSW-1:0] cfg_ws_sram,
  input  logic           h_rd,
  input  logic           h_wr,
  input  logic [AW-1:0]  h_addr,
  input  logic [DW-1:0]  h_wdata,
  input  logic [DW/8-1:0] h_be,
  output logic           h_wait,
  output logic [DW-1:0]  h_rdata,
  input  logic           p_req,
  input  logic           p_we,
  input  logic [AW-1:0]  p_addr,
  input  logic [DW-1:0]  p_wdata,
  input  logic [DW/8-1:0] p_be,
  output logic           p_ack,
  output logic [DW-1:0]  p_rdata,
  output logic           m_cs_flash,
  output logic           m_cs_sram,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  output logic [DW/8-1:0] m_be,
  input  logic [DW-1:0]  m_rdata
);
  localparam int BW = DW / 8;

  typedef enum logic [1:0] {OWN_NONE, OWN_P, OWN_HW, OWN_HR} own_t;

  own_t           owner;
  logic [WSW-1:0] cnt;
  logic           last_host;
  logic           buf_full;
  logic [AW-1:0]  buf_addr;
  logic [DW-1:0]  buf_data;
  logic [BW-1:0]  buf_be;
  logic           rd_done;
  logic [DW-1:0]  rd_q;

  logic           busy, done, hr_pend, host_pend, wr_acc;
  logic           grant_p, grant_hw, grant_hr;
  logic [WSW-1:0] cur_ws;

  assign busy      = owner != OWN_NONE;
  assign m_addr    = (owner == OWN_P) ? p_addr : (owner == OWN_HW) ? buf_addr : h_addr;
  assign m_wdata   = (owner == OWN_HW) ? buf_data : p_wdata;
  assign m_be      = (owner == OWN_HW) ? buf_be : (owner == OWN_P) ? p_be : {BW{1'b1}};
  assign m_we      = (owner == OWN_HW) || (owner == OWN_P && p_we);
  assign m_cs_flash = busy && m_addr[AW-1];
  assign m_cs_sram  = busy && !m_addr[AW-1];
  assign cur_ws    = m_addr[AW-1] ? cfg_ws_flash : cfg_ws_sram;
  assign done      = busy && cnt == cur_ws;

  assign p_ack     = done && owner == OWN_P;
  assign p_rdata   = m_rdata;
  assign h_rdata   = rd_q;
  assign h_wait    = (h_rd && !rd_done) || (h_wr && buf_full);
  assign wr_acc    = h_wr && !buf_full;

  assign hr_pend   = h_rd && !rd_done;
  assign host_pend = buf_full || hr_pend;
  assign grant_p   = p_req && (last_host || !host_pend);
  assign grant_hw  = !grant_p && buf_full;
  assign grant_hr  = !grant_p && !buf_full && hr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner     <= OWN_NONE;
      cnt       <= '0;
      last_host <= 1'b0;
      buf_full  <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      buf_be    <= '0;
      rd_done   <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (!busy) begin
        cnt <= '0;
        if (grant_p)       owner <= OWN_P;
        else if (grant_hw) owner <= OWN_HW;
        else if (grant_hr) owner <= OWN_HR;
      end else if (done) begin
        owner     <= OWN_NONE;
        last_host <= owner != OWN_P;
        if (owner == OWN_HW) buf_full <= 1'b0;
        if (owner == OWN_HR) begin
          rd_done <= 1'b1;
          rd_q    <= m_rdata;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (wr_acc) begin
        buf_full <= 1'b1;
        buf_addr <= h_addr;
        buf_data <= h_wdata;
        buf_be   <= h_be;
      end
      if (h_rd && rd_done) rd_done <= 1'b0;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= cur_ws); // R1

  AST_WR_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr && !h_wait |=> buf_full); // R2

  AST_POST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !(done && owner == OWN_HW) |=> buf_full && $stable(buf_data) && $stable(buf_addr)); // R3

  AST_HR_AFTER_HW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && buf_full |=> owner != OWN_HR); // R4

  AST_ALT_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && last_host && p_req |=> owner == OWN_P); // R5

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd && !h_wr && $past(h_rd) && $fell(h_wait) |-> $past(owner == OWN_HR)); // R6

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    p_ack |=> !p_ack); // R9
endmodule

// File: tb/shmem_arb_test.sv
module shmem_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_ws_flash = 2'd0, cfg_ws_sram = 2'd0;
  logic        h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [1:0]  h_be = '0;
  logic        h_wait;
  logic [15:0] h_rdata;
  logic        p_req = 1'b0, p_we = 1'b0;
  logic [7:0]  p_addr = '0;
  logic [15:0] p_wdata = '0;
  logic [1:0]  p_be = '0;
  logic        p_ack;
  logic [15:0] p_rdata;
  logic        m_cs_flash, m_cs_sram, m_we;
  logic [7:0]  m_addr;
  logic [15:0] m_wdata, m_rdata;
  logic [1:0]  m_be;

  shmem_arb #(.AW(8), .DW(16), .WSW(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ws_flash(cfg_ws_flash), .cfg_ws_sram(cfg_ws_sram),
    .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .h_wait(h_wait), .h_rdata(h_rdata),
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_be(p_be),
    .p_ack(p_ack), .p_rdata(p_rdata),
    .m_cs_flash(m_cs_flash), .m_cs_sram(m_cs_sram), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [15:0] mem [256];
  assign m_rdata = mem[m_addr];
  always @(posedge clk)
    if ((m_cs_flash || m_cs_sram) && m_we) begin
      if (m_be[0]) mem[m_addr][7:0]  <= m_wdata[7:0];
      if (m_be[1]) mem[m_addr][15:8] <= m_wdata[15:8];
    end

  int both_cs = 0;
  bit seen_f = 0, seen_s = 0, prev_cs = 0;
  int log_n = 0;
  logic [7:0] log_addr [8];
  logic       log_we [8];
  always @(negedge clk) begin
    if (m_cs_flash && m_cs_sram) both_cs++;
    if (m_cs_flash) seen_f = 1;
    if (m_cs_sram)  seen_s = 1;
    if ((m_cs_flash || m_cs_sram) && !prev_cs && log_n < 8) begin
      log_addr[log_n] = m_addr;
      log_we[log_n]   = m_we;
      log_n++;
    end
    prev_cs = m_cs_flash || m_cs_sram;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be,
                            output int waits);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_be = be; h_wr = 1'b1; waits = 0;
    while (1) begin
      #1;
      if (!h_wait) break;
      waits++;
      @(negedge clk);
    end
    @(posedge clk); #1 h_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [15:0] d, output int waits);
    @(negedge clk);
    h_addr = a; h_rd = 1'b1; waits = 0;
    while (1) begin
      #1;
      if (!h_wait) break;
      waits++;
      @(negedge clk);
    end
    d = h_rdata;
    @(posedge clk); #1 h_rd = 1'b0;
  endtask

  task automatic proc_access(input logic we, input logic [7:0] a, input logic [15:0] d,
                             output logic [15:0] rd, output int acks);
    @(negedge clk);
    p_we = we; p_addr = a; p_wdata = d; p_be = 2'b11; p_req = 1'b1;
    while (1) begin
      #1;
      if (p_ack) break;
      @(negedge clk);
    end
    rd = p_rdata; acks = 1;
    @(posedge clk); #1 p_req = 1'b0;
    @(negedge clk); #1;
    if (p_ack) acks++;
  endtask

  // {flash, wait states, expected sampled WAIT cycles = ws + 2}
  localparam bit [6:0] VEC [8] = '{
    {1'b0, 2'd0, 4'd2}, {1'b0, 2'd1, 4'd3}, {1'b0, 2'd2, 4'd4}, {1'b0, 2'd3, 4'd5},
    {1'b1, 2'd0, 4'd2}, {1'b1, 2'd1, 4'd3}, {1'b1, 2'd2, 4'd4}, {1'b1, 2'd3, 4'd5}};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, r1, r2;
    int w, w2, acks;
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;

    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    chk(!h_wait && !p_ack && !m_cs_flash && !m_cs_sram, "R8 reset outputs",
        {h_wait, p_ack, m_cs_flash, m_cs_sram}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R6 / R7: idle host reads per region and wait setting
    for (int i = 0; i < 8; i++) begin
      logic fl;
      logic [1:0] ws;
      logic [7:0] a;
      fl = VEC[i][6]; ws = VEC[i][5:4];
      a = fl ? 8'h80 + 8'(i) : 8'h10 + 8'(i);
      if (fl) begin cfg_ws_flash = ws; cfg_ws_sram = ~ws; end
      else    begin cfg_ws_sram = ws;  cfg_ws_flash = ~ws; end
      mem[a] = 16'hA000 + 16'(i);
      seen_f = 0; seen_s = 0;
      host_read(a, d, w);
      chk(w == int'(VEC[i][3:0]), "R1 wait cycles", w, int'(VEC[i][3:0]));
      chk(d == 16'hA000 + 16'(i), "R6 read data at wait release", d, 16'hA000 + 16'(i));
      chk(seen_f == fl && seen_s == !fl, "R7 chip select by address msb",
          {seen_f, seen_s}, {fl, !fl});
    end

    // R2: posted write with byte enable
    cfg_ws_sram = 2'd1; cfg_ws_flash = 2'd2;
    mem[8'h40] = 16'h1234;
    host_write(8'h40, 16'hABCD, 2'b01, w);
    chk(w == 0, "R2 write accepted at once", w, 0);
    repeat (6) @(negedge clk);
    host_read(8'h40, d, w);
    chk(d == 16'h12CD, "R2 byte-enabled posted write", d, 16'h12CD);

    // R3: second write while buffer full
    cfg_ws_sram = 2'd3;
    host_write(8'h30, 16'h3030, 2'b11, w);
    chk(w == 0, "R3 first write no wait", w, 0);
    host_write(8'h31, 16'h3131, 2'b11, w2);
    chk(w2 == 5, "R3 second write held until drain", w2, 5);
    repeat (8) @(negedge clk);
    host_read(8'h30, d, w);
    chk(d == 16'h3030, "R3 first write landed", d, 16'h3030);
    host_read(8'h31, d, w);
    chk(d == 16'h3131, "R3 second write landed", d, 16'h3131);

    // R9: processor write and read
    cfg_ws_flash = 2'd1;
    proc_access(1'b1, 8'h90, 16'h7777, r1, acks);
    chk(acks == 1, "R9 single-cycle ack on write", acks, 1);
    chk(mem[8'h90] == 16'h7777, "R9 processor write data", mem[8'h90], 16'h7777);
    proc_access(1'b0, 8'h90, 16'h0000, r1, acks);
    chk(r1 == 16'h7777 && acks == 1, "R9 processor read data", r1, 16'h7777);

    // R4 / R5: processor, posted write, processor, held host read
    cfg_ws_sram = 2'd3; cfg_ws_flash = 2'd3;
    mem[8'h85] = 16'h5858; mem[8'h86] = 16'h6868; mem[8'h20] = 16'h1111;
    repeat (2) @(negedge clk);
    log_n = 0;
    fork
      begin
        proc_access(1'b0, 8'h85, 16'h0000, r1, acks);
        proc_access(1'b0, 8'h86, 16'h0000, r2, acks);
      end
      begin
        @(negedge clk); @(negedge clk);
        host_write(8'h20, 16'hBEEF, 2'b11, w);
        host_read(8'h20, d, w2);
      end
    join
    chk(w == 0, "R2 write posted during processor access", w, 0);
    chk(log_n == 4, "R5 four bus accesses", log_n, 4);
    chk(log_addr[0] == 8'h85 && !log_we[0], "R5 first processor access", log_addr[0], 8'h85);
    chk(log_addr[1] == 8'h20 && log_we[1], "R5 posted write second", log_addr[1], 8'h20);
    chk(log_addr[2] == 8'h86 && !log_we[2], "R5 processor between write and read", log_addr[2], 8'h86);
    chk(log_addr[3] == 8'h20 && !log_we[3], "R5 host read last", log_addr[3], 8'h20);
    chk(d == 16'hBEEF, "R4 read returns posted data", d, 16'hBEEF);
    chk(r1 == 16'h5858 && r2 == 16'h6868, "R5 processor data", r2, 16'h6868);
    chk(w2 >= 12, "R4 read held through three accesses", w2, 12);

    // R8: reset discards a posted write
    mem[8'h50] = 16'h0000;
    host_write(8'h50, 16'h5555, 2'b11, w);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!h_wait && !m_cs_flash && !m_cs_sram && !p_ack, "R8 idle during reset",
        {h_wait, m_cs_flash, m_cs_sram, p_ack}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    host_read(8'h50, d, w);
    chk(d == 16'h0000, "R8 posted write cleared", d, 16'h0000);

    chk(both_cs == 0, "R7 chip selects exclusive", both_cs, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule